// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a single DRAM read or write burst. With each command it receives the column address, a two-bit burst-length mode field and the address-line-12 bit. From the mode field and that bit it decides whether the burst is a 4-beat chop or a full 8-beat burst.

It then issues one column per clock cycle, starting at the command's column. Only the low two or three column bits advance, modulo the burst length. The sequence therefore wraps around inside the aligned 4- or 8-column block and never carries into the upper bits. Each beat comes with a valid strobe and a last-beat flag. A flag also marks bursts that were launched with the reserved mode code.

A new command is taken only when the sequencer is idle or showing its last beat. This lets bursts run back to back with no gap.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, beatValid, beatLast and modeErr are low and cmdReady is high.
- R2: When cmdValid is high and cmdReady is high at a clock edge, the first beat appears after that edge: beatValid is high and beatCol equals cmdCol.
- R3: Mode code 2'b00 gives a burst of 8 beats.
- R4: Mode code 2'b10 gives a burst of 4 beats.
- R5: Mode code 2'b01 sets the length per command. otfBit = 0 gives 4 beats and otfBit = 1 gives 8 beats.
- R6: Mode code 2'b11 gives 8 beats, and modeErr is high on each of those beats. For any other code, modeErr stays low.
- R7: In an 8-beat burst, beatCol[2:0] goes up by one per beat modulo 8, and bits [COL_W-1:3] keep the value of the start column.
- R8: In a 4-beat burst, beatCol[1:0] goes up by one per beat modulo 4, and bits [COL_W-1:2] keep the value of the start column.
- R9: beatLast is high on the final beat of a burst and on no other cycle.
- R10: cmdReady is low on every beat except the last. A command presented then is dropped and leaves the running sequence unchanged.
- R11: A command accepted on the last beat starts its first beat in the very next cycle, with no idle cycle between the bursts.
- R12: In the fixed modes (2'b00 and 2'b10), the value of otfBit has no effect on the burst length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdCol | input | COL_W | Start column of the command |
| blMode | input | 2 | Burst-length mode code |
| otfBit | input | 1 | Address line 12 sampled with the command |
| cmdReady | output | 1 | Sequencer can accept a command this cycle |
| beatValid | output | 1 | A beat address is presented |
| beatCol | output | COL_W | Column address of the current beat |
| beatLast | output | 1 | Current beat is the last of its burst |
| modeErr | output | 1 | Burst was launched with the reserved mode code |

## Verification
Two functions can fall in the same cycle: ending a burst and accepting the next command. The bench provokes this by waiting until beatLast is visible and presenting a new command in that same cycle. The judgement is that the old burst's last beat is followed directly by the new burst's first column, with no idle cycle and no extra beat. A command offered in the middle of a burst is also judged: the scoreboard must see no stray beats from it and the running sequence must not be disturbed.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam logic [1:0] MODE_FIX8 = 2'b00;
  localparam logic [1:0] MODE_OTF  = 2'b01;
  localparam logic [1:0] MODE_FIX4 = 2'b10;
  localparam logic [1:0] MODE_RSVD = 2'b11;

  typedef struct packed {
    logic load;   // capture command column
    logic step;   // advance to next beat
    logic chop;   // current burst is 4 beats
  } ctrlStrobes_t;
endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [1:0]   blMode,
  input  logic         otfBit,
  output logic         cmdReady,
  output logic         beatValid,
  output logic         beatLast,
  output logic         modeErr,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_CHOP = CNT_W'(3);

  logic             busy;
  logic             chopQ;
  logic             errQ;
  logic [CNT_W-1:0] beatCnt;
  logic             onLast;
  logic             accept;
  logic             chopSel;

  assign onLast   = busy && (beatCnt == (chopQ ? LAST_CHOP : LAST_FULL));
  assign cmdReady = !busy || onLast;
  assign accept   = cmdValid && cmdReady;
  assign chopSel  = (blMode == MODE_FIX4) || ((blMode == MODE_OTF) && !otfBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      chopQ   <= 1'b0;
      errQ    <= 1'b0;
      beatCnt <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      chopQ   <= chopSel;
      errQ    <= (blMode == MODE_RSVD);
      beatCnt <= '0;
    end else if (onLast) begin
      busy    <= 1'b0;
      errQ    <= 1'b0;
    end else if (busy) begin
      beatCnt <= beatCnt + CNT_W'(1);
    end
  end

  assign strobes.load = accept;
  assign strobes.step = busy && !onLast;
  assign strobes.chop = chopQ;

  assign beatValid = busy;
  assign beatLast  = onLast;
  assign modeErr   = errQ;
endmodule

// File: rtl/bcs_dp.sv
module bcs_dp
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [COL_W-1:0] cmdCol,
  output logic [COL_W-1:0] beatCol
);
  logic [COL_W-1:0] colQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colQ <= '0;
    end else if (strobes.load) begin
      colQ <= cmdCol;
    end else if (strobes.step) begin
      if (strobes.chop) colQ[1:0] <= colQ[1:0] + 2'd1;
      else              colQ[2:0] <= colQ[2:0] + 3'd1;
    end
  end

  assign beatCol = colQ;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [COL_W-1:0] cmdCol,
  input  logic [1:0]       blMode,
  input  logic             otfBit,
  output logic             cmdReady,
  output logic             beatValid,
  output logic [COL_W-1:0] beatCol,
  output logic             beatLast,
  output logic             modeErr
);
  ctrlStrobes_t strobes;

  bcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .blMode(blMode),
    .otfBit(otfBit), .cmdReady(cmdReady), .beatValid(beatValid),
    .beatLast(beatLast), .modeErr(modeErr), .strobes(strobes)
  );

  bcs_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdCol(cmdCol),
    .beatCol(beatCol)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic [COL_W-1:0] cmdCol,
  input logic             beatValid,
  input logic [COL_W-1:0] beatCol,
  input logic             beatLast,
  input logic             modeErr
);
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady |=> beatValid && (beatCol == $past(cmdCol)));

  // R7 and R8: low two bits always step by one inside a burst
  p_low_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !beatLast && !cmdValid |=> beatCol[1:0] == $past(beatCol[1:0]) + 2'd1);

  p_upper_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !beatLast |=> beatCol[COL_W-1:3] == $past(beatCol[COL_W-1:3]));

  p_last_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    beatLast |-> beatValid);

  p_idle_after_last_r9: assert property (@(posedge clk) disable iff (!rstN)
    beatLast && !cmdValid |=> !beatValid && !beatLast);

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !beatLast |-> !cmdReady);

  p_err_with_beat_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> beatValid);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdCol(cmdCol), .beatValid(beatValid), .beatCol(beatCol),
  .beatLast(beatLast), .modeErr(modeErr)
);

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;
  localparam int COL_W = 10;

  typedef struct {
    logic [COL_W-1:0] col;
    logic             last;
    logic             err;
    string            tag;
  } beat_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdValid = 1'b0;
  logic [COL_W-1:0] cmdCol = '0;
  logic [1:0]       blMode = 2'b00;
  logic             otfBit = 1'b0;
  logic             cmdReady, beatValid, beatLast, modeErr;
  logic [COL_W-1:0] beatCol;

  beat_t expQ[$];
  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCol(cmdCol),
    .blMode(blMode), .otfBit(otfBit), .cmdReady(cmdReady),
    .beatValid(beatValid), .beatCol(beatCol), .beatLast(beatLast),
    .modeErr(modeErr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pops expected beats as the design shows them
  always @(negedge clk) begin
    if (rstN && beatValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected beat col", int'(beatCol), 0);
      end else begin
        beat_t e;
        e = expQ.pop_front();
        check(beatCol == e.col, e.tag, "beat col", int'(beatCol), int'(e.col));
        check(beatLast == e.last, e.tag, "beatLast", int'(beatLast), int'(e.last));
        check(modeErr == e.err, e.tag, "modeErr", int'(modeErr), int'(e.err));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      check(1'b0, "R9", "watchdog expired", cycles, 0);
      finish();
    end
  end

  // called just after a negedge; returns at the negedge of the first beat
  task automatic sendCmd(input logic [COL_W-1:0] col, input logic [1:0] mode,
                         input logic otf, input string tag);
    int n;
    int mask;
    n = ((mode == 2'b10) || (mode == 2'b01 && !otf)) ? 4 : 8;
    mask = n - 1;
    for (int k = 0; k < n; k++) begin
      beat_t b;
      b.col  = COL_W'((int'(col) & ~mask) | ((int'(col) + k) & mask));
      b.last = (k == n - 1);
      b.err  = (mode == 2'b11);
      b.tag  = tag;
      expQ.push_back(b);
    end
    cmdValid = 1'b1; cmdCol = col; blMode = mode; otfBit = otf;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitLast();
    while (!beatLast) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    waitLast();
    @(negedge clk);
    check(!beatValid, tag, "idle after burst", int'(beatValid), 0);
    check(expQ.size() == 0, tag, "beats outstanding", expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!beatValid && !beatLast && !modeErr, "R1", "reset outputs",
          {beatValid, beatLast, modeErr}, 0);
    check(cmdReady, "R1", "cmdReady at reset", int'(cmdReady), 1);
    rstN = 1'b1;
    @(negedge clk);

    sendCmd(10'h000, 2'b00, 1'b0, "R3");   drain("R3");
    sendCmd(10'h2B5, 2'b00, 1'b1, "R7");   drain("R7");
    sendCmd(10'h123, 2'b10, 1'b0, "R4");   drain("R4");
    sendCmd(10'h3FE, 2'b10, 1'b1, "R8");   drain("R8");
    sendCmd(10'h0C7, 2'b01, 1'b0, "R5");   drain("R5");
    sendCmd(10'h1E9, 2'b01, 1'b1, "R5");   drain("R5");
    sendCmd(10'h04D, 2'b11, 1'b0, "R6");   drain("R6");
    sendCmd(10'h155, 2'b00, 1'b0, "R12");  drain("R12");
    sendCmd(10'h156, 2'b10, 1'b1, "R12");  drain("R12");

    // R2: first beat directly after the accepting edge
    sendCmd(10'h0AA, 2'b00, 1'b0, "R2");
    check(beatValid && beatCol == 10'h0AA, "R2", "first beat", int'(beatCol), 'h0AA);
    // R10: command during a non-last beat is dropped
    check(!cmdReady, "R10", "cmdReady mid burst", int'(cmdReady), 0);
    cmdValid = 1'b1; cmdCol = 10'h3C3; blMode = 2'b10; otfBit = 1'b0;
    @(negedge clk);
    cmdValid = 1'b0;
    drain("R10");

    // R11: back-to-back bursts, new command on the last beat
    sendCmd(10'h013, 2'b10, 1'b0, "R11");
    waitLast();
    check(cmdReady, "R11", "cmdReady on last", int'(cmdReady), 1);
    sendCmd(10'h2F1, 2'b00, 1'b0, "R11");
    check(beatValid, "R11", "no gap between bursts", int'(beatValid), 1);
    waitLast();
    sendCmd(10'h0F6, 2'b01, 1'b0, "R11");
    drain("R11");

    repeat (3) @(negedge clk);
    check(!beatValid && !beatLast && !modeErr, "R9", "quiet when idle",
          {beatValid, beatLast, modeErr}, 0);
    finish();
  end
endmodule